// File: doc/BRIEF.md
# Packing Data FIFO with Burst Request Generation

This block sits between a 32-bit host register port (CPU or DMA) and a byte-wide serial bus engine. It buffers up to eight 32-bit words, held internally as a ring of 32 byte slots. In transmit direction the host writes words that are split into bytes and handed to the engine one at a time. In receive direction bytes from the engine are gathered into host words. The width of each host access is set by an alignment setting: one, two or four bytes per access.

A package is a configured number of bytes that belongs to one transfer. A start pulse opens a new package and empties the buffer. As the package proceeds, the block compares the bytes still owed to the host and the room or fill in the buffer against a configured burst size. From this it raises one of four data requests: single, burst, last single or last burst. The four are merged into one interrupt line, so a DMA engine can keep moving data without gaps until the package is finished. Misuse from either side sets one of four sticky error flags: transmit overflow, transmit underflow, receive overflow and receive underflow. The offending access is dropped.

Top module: `byte_pack_fifo`

## Requirements
- R1: After synchronous reset, tx_valid, rx_ready, host_ack, all four requests, data_irq and err_flags are all low.
- R2: In transmit direction (cfg_rx=0) a stored host word leaves on tx_byte least significant byte first, one byte per cycle in which tx_valid and tx_ready are both high.
- R3: cfg_align selects the bytes per host access: 0 takes host_wdata[7:0] only, 1 takes [15:0], 2 and 3 take all 32 bits.
- R4: In receive direction (cfg_rx=1) bytes are packed into host_rdata least significant byte first. When fewer package bytes remain than one access width, the read returns only those bytes and the upper bytes are zero.
- R5: A transmit write that meets the end of the package stores only the bytes still owed to the package. Its surplus bytes never appear on tx_byte.
- R6: While bytes remaining in the package (rem) are at least cfg_burst (nonzero), and free space (transmit) or filled bytes (receive) are at least cfg_burst, req_burst is raised. If rem equals cfg_burst, req_last_burst is raised instead.
- R7: When rem is below cfg_burst and the space covers min(rem, access width), req_single is raised. If rem is no more than the access width, req_last_single is raised instead. No request is raised when rem is zero.
- R8: data_irq is high exactly when one of the four requests is high, and at most one request is high at a time.
- R9: A host write with too little free space, or after the package is complete, is discarded and sets err_flags[0] (transmit overflow).
- R10: tx_ready high while the buffer is empty and the package is unfinished sets err_flags[1] (transmit underflow).
- R11: rx_ready is low when the buffer is full or the package is complete. An rx_valid byte offered then is dropped and sets err_flags[2] (receive overflow).
- R12: A host read with too few buffered bytes, or after the package is complete, removes nothing, returns zero and sets err_flags[3] (receive underflow).
- R13: Error flags stay set until a cycle with the matching err_clr bit high. Bits of err_clr that are set clear only their own flag.
- R14: host_ack pulses high for one cycle, in the cycle after host_req is sampled, and host_rdata is valid with it. A held host_req is served every second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rx | input | 1 | Direction: 0 transmit, 1 receive |
| cfg_align | input | 2 | Host access width select |
| cfg_burst | input | 6 | Burst size in bytes, 0 disables bursts |
| cfg_tx_pkg | input | 16 | Transmit package size in bytes |
| cfg_rx_pkg | input | 16 | Receive package size in bytes |
| pkg_start | input | 1 | Opens a new package and empties the buffer |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | Host access is a write |
| host_wdata | input | 32 | Host write word |
| host_ack | output | 1 | Host access completed |
| host_rdata | output | 32 | Host read word |
| tx_valid | output | 1 | Transmit byte available |
| tx_byte | output | 8 | Transmit byte |
| tx_ready | input | 1 | Engine takes the transmit byte |
| rx_valid | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Buffer can accept a received byte |
| req_single | output | 1 | Single access request |
| req_burst | output | 1 | Burst request |
| req_last_single | output | 1 | Final single access request |
| req_last_burst | output | 1 | Final burst request |
| data_irq | output | 1 | Merged data request interrupt |
| err_clr | input | 4 | Write-one-to-clear for err_flags |
| err_flags | output | 4 | Sticky errors: [0] tx overflow, [1] tx underflow, [2] rx overflow, [3] rx underflow |

## Verification
The hardest state to reach is a full 32-byte ring meeting one more write or byte. Here the overflow flag must set while the stored stream stays intact. The bench reaches it by opening a package longer than the buffer and filling all eight words with no bus activity. It then offers one more word, or one more byte in receive direction, and drains the ring to show that exactly 32 bytes remain. The switch from burst to last single also takes care to reach. A package that is not a whole number of bursts is stepped word by word, and the request lines are read after each access.

// File: rtl/pkfifo_pkg.sv
package pkfifo_pkg;

    typedef enum logic [1:0] {
        ALIGN_BYTE  = 2'd0,
        ALIGN_HALF  = 2'd1,
        ALIGN_WORD  = 2'd2,
        ALIGN_WORD3 = 2'd3
    } align_e;

    typedef struct packed {
        logic last_burst;
        logic burst;
        logic last_single;
        logic single;
    } dreq_s;

    localparam int ERR_TX_OVF = 0;
    localparam int ERR_TX_UNF = 1;
    localparam int ERR_RX_OVF = 2;
    localparam int ERR_RX_UNF = 3;
    localparam int ERR_N      = 4;

    function automatic logic [2:0] unit_bytes(input logic [1:0] sel);
        case (align_e'(sel))
            ALIGN_BYTE: return 3'd1;
            ALIGN_HALF: return 3'd2;
            default:    return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/pkfifo_store.sv
module pkfifo_store #(
    parameter  int BYTES = 32,
    localparam int PW    = $clog2(BYTES),
    localparam int CW    = $clog2(BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic [2:0]    push_n,
    input  logic [31:0]   push_data,
    input  logic [2:0]    pop_n,
    output logic [31:0]   peek,
    output logic [CW-1:0] count
);
    logic [7:0]    mem [BYTES];
    logic [PW-1:0] wptr, rptr;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            wptr  <= wptr + PW'(push_n);
            rptr  <= rptr + PW'(pop_n);
            count <= count + CW'(push_n) - CW'(pop_n);
        end
    end

    always_ff @(posedge clk) begin
        if (!clear) begin
            for (int i = 0; i < 4; i++) begin
                if (3'(i) < push_n)
                    mem[wptr + PW'(i)] <= push_data[8*i +: 8];
            end
        end
    end

    for (genvar g = 0; g < 4; g++) begin : g_peek
        assign peek[8*g +: 8] = mem[rptr + PW'(g)];
    end
endmodule

// File: rtl/pkfifo_reqgen.sv
module pkfifo_reqgen
    import pkfifo_pkg::*;
#(
    parameter int RW = 16,
    parameter int SW = 6,
    parameter int BW = 6
) (
    input  logic [RW-1:0] rem,
    input  logic [SW-1:0] space,
    input  logic [BW-1:0] burst,
    input  logic [2:0]    unit,
    output dreq_s         req
);
    logic [RW-1:0] need, sp, bu, un;

    always_comb begin
        sp   = RW'(space);
        bu   = RW'(burst);
        un   = RW'(unit);
        need = (rem < un) ? rem : un;
        req  = '0;
        if (rem != '0) begin
            if (bu != '0 && rem >= bu) begin
                if (sp >= bu) begin
                    if (rem == bu) req.last_burst = 1'b1;
                    else           req.burst      = 1'b1;
                end
            end else if (sp >= need) begin
                if (rem <= un) req.last_single = 1'b1;
                else           req.single      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pkfifo_errs.sv
module pkfifo_errs #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)         flags[g] <= 1'b0;
            else if (set[g]) flags[g] <= 1'b1;
            else if (clr[g]) flags[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/byte_pack_fifo.sv
module byte_pack_fifo
    import pkfifo_pkg::*;
#(
    parameter  int DEPTH = 8,
    parameter  int PKG_W = 16,
    localparam int BYTES = DEPTH * 4,
    localparam int BW    = $clog2(BYTES) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_rx,
    input  logic [1:0]       cfg_align,
    input  logic [BW-1:0]    cfg_burst,
    input  logic [PKG_W-1:0] cfg_tx_pkg,
    input  logic [PKG_W-1:0] cfg_rx_pkg,
    input  logic             pkg_start,
    input  logic             host_req,
    input  logic             host_we,
    input  logic [31:0]      host_wdata,
    output logic             host_ack,
    output logic [31:0]      host_rdata,
    output logic             tx_valid,
    output logic [7:0]       tx_byte,
    input  logic             tx_ready,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    output logic             rx_ready,
    output logic             req_single,
    output logic             req_burst,
    output logic             req_last_single,
    output logic             req_last_burst,
    output logic             data_irq,
    input  logic [3:0]       err_clr,
    output logic [3:0]       err_flags
);
    localparam int CW = $clog2(BYTES + 1);

    logic [2:0]       unit, n_h, push_n, pop_n;
    logic [PKG_W-1:0] hcnt, bcnt, pkg, rem_h;
    logic [CW-1:0]    count, free_sp, space;
    logic [31:0]      peek, push_data, rd_word;
    logic             access, wr_ok, wr_bad, rd_ok, rd_bad;
    logic             tx_fire, rx_fire, tx_starve, rx_drop;
    logic [ERR_N-1:0] err_set;
    dreq_s            req;

    assign unit    = unit_bytes(cfg_align);
    assign pkg     = cfg_rx ? cfg_rx_pkg : cfg_tx_pkg;
    assign rem_h   = pkg - hcnt;
    assign n_h     = (rem_h < PKG_W'(unit)) ? rem_h[2:0] : unit;
    assign free_sp = CW'(BYTES) - count;
    assign space   = cfg_rx ? count : free_sp;

    // host side
    assign access = host_req && !host_ack && !pkg_start;
    assign wr_ok  = access && host_we && !cfg_rx && rem_h != '0 && free_sp >= CW'(n_h);
    assign wr_bad = access && host_we && !cfg_rx && !wr_ok;
    assign rd_ok  = access && !host_we && cfg_rx && rem_h != '0 && count >= CW'(n_h);
    assign rd_bad = access && !host_we && cfg_rx && !rd_ok;

    // bus side
    assign tx_valid  = !cfg_rx && count != '0;
    assign tx_byte   = peek[7:0];
    assign tx_fire   = tx_valid && tx_ready && !pkg_start;
    assign tx_starve = !cfg_rx && tx_ready && count == '0 && bcnt < pkg;
    assign rx_ready  = cfg_rx && count != CW'(BYTES) && bcnt < pkg;
    assign rx_fire   = rx_valid && rx_ready && !pkg_start;
    assign rx_drop   = cfg_rx && rx_valid && !rx_ready;

    assign push_n    = wr_ok ? n_h : (rx_fire ? 3'd1 : 3'd0);
    assign push_data = wr_ok ? host_wdata : {24'h0, rx_byte};
    assign pop_n     = rd_ok ? n_h : (tx_fire ? 3'd1 : 3'd0);

    for (genvar g = 0; g < 4; g++) begin : g_mask
        assign rd_word[8*g +: 8] = (3'(g) < n_h) ? peek[8*g +: 8] : 8'h00;
    end

    pkfifo_store #(.BYTES(BYTES)) u_store (
        .clk(clk), .rst(rst), .clear(pkg_start),
        .push_n(push_n), .push_data(push_data),
        .pop_n(pop_n), .peek(peek), .count(count)
    );

    always_ff @(posedge clk) begin
        if (rst || pkg_start) begin
            hcnt <= '0;
            bcnt <= '0;
        end else begin
            if (wr_ok || rd_ok)     hcnt <= hcnt + PKG_W'(n_h);
            if (tx_fire || rx_fire) bcnt <= bcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_ack   <= 1'b0;
            host_rdata <= '0;
        end else begin
            host_ack   <= access;
            host_rdata <= rd_ok ? rd_word : 32'h0;
        end
    end

    pkfifo_reqgen #(.RW(PKG_W), .SW(CW), .BW(BW)) u_req (
        .rem(rem_h), .space(space), .burst(cfg_burst), .unit(unit), .req(req)
    );

    assign req_single      = req.single;
    assign req_burst       = req.burst;
    assign req_last_single = req.last_single;
    assign req_last_burst  = req.last_burst;
    assign data_irq        = |req;

    always_comb begin
        err_set             = '0;
        err_set[ERR_TX_OVF] = wr_bad;
        err_set[ERR_TX_UNF] = tx_starve;
        err_set[ERR_RX_OVF] = rx_drop;
        err_set[ERR_RX_UNF] = rd_bad;
    end

    pkfifo_errs #(.N(ERR_N)) u_errs (
        .clk(clk), .rst(rst), .set(err_set), .clr(err_clr), .flags(err_flags)
    );
endmodule

// File: rtl/pkfifo_checker.sv
module pkfifo_checker (
    input logic       clk,
    input logic       rst,
    input logic       cfg_rx,
    input logic       host_req,
    input logic       host_we,
    input logic       host_ack,
    input logic       tx_valid,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic [3:0] reqs,
    input logic       data_irq,
    input logic [3:0] err_clr,
    input logic [3:0] err_flags
);
    p_one_req_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(reqs) && (data_irq == ($countones(reqs) == 1)));

    p_ack_pulse_r14: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack);

    p_ack_cause_r14: assert property (@(posedge clk) disable iff (rst)
        host_ack |-> $past(host_req));

    p_sticky_r13: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((err_flags & $past(err_flags & ~err_clr)) == $past(err_flags & ~err_clr)));

    p_txovf_src_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flags[0]) |-> $past(host_req && host_we));

    p_rxovf_src_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flags[2]) |-> $past(rx_valid));

    p_tx_dir_r2: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !cfg_rx);

    p_rx_dir_r11: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> cfg_rx);
endmodule

bind byte_pack_fifo pkfifo_checker u_chk (
    .clk(clk), .rst(rst), .cfg_rx(cfg_rx),
    .host_req(host_req), .host_we(host_we), .host_ack(host_ack),
    .tx_valid(tx_valid), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .reqs({req_last_burst, req_burst, req_last_single, req_single}),
    .data_irq(data_irq), .err_clr(err_clr), .err_flags(err_flags)
);

// File: tb/byte_pack_fifo_test.sv
`timescale 1ns/1ps
module byte_pack_fifo_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_rx = 1'b0;
    logic [1:0]  cfg_align = 2'd2;
    logic [5:0]  cfg_burst = '0;
    logic [15:0] cfg_tx_pkg = '0, cfg_rx_pkg = '0;
    logic        pkg_start = 1'b0, host_req = 1'b0, host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        host_ack;
    logic [31:0] host_rdata;
    logic        tx_valid, tx_ready = 1'b0;
    logic [7:0]  tx_byte;
    logic        rx_valid = 1'b0, rx_ready;
    logic [7:0]  rx_byte = '0;
    logic        req_single, req_burst, req_last_single, req_last_burst, data_irq;
    logic [3:0]  err_clr = '0, err_flags;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    byte_pack_fifo uut (.*);

    // align, pkg, host word, byte count, expected bytes (first byte in [7:0])
    localparam bit [71:0] VEC [6] = '{
        {2'd2, 3'd4, 32'h44332211, 3'd4, 32'h44332211},
        {2'd1, 3'd4, 32'hAABBCCDD, 3'd2, 32'h0000CCDD},
        {2'd0, 3'd4, 32'h12345678, 3'd1, 32'h00000078},
        {2'd2, 3'd3, 32'hDEADBEEF, 3'd3, 32'h00ADBEEF},
        {2'd3, 3'd4, 32'h01020304, 3'd4, 32'h01020304},
        {2'd1, 3'd1, 32'h0000F00D, 3'd1, 32'h0000000D}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start_pkg(input logic rx, input logic [1:0] al, input logic [5:0] bu,
                             input logic [15:0] tp, input logic [15:0] rp);
        cfg_rx = rx; cfg_align = al; cfg_burst = bu; cfg_tx_pkg = tp; cfg_rx_pkg = rp;
        pkg_start = 1'b1;
        tick();
        pkg_start = 1'b0;
    endtask

    task automatic clr_all;
        err_clr = 4'hF;
        tick();
        err_clr = 4'h0;
    endtask

    task automatic host_wr(input logic [31:0] w);
        host_req = 1'b1; host_we = 1'b1; host_wdata = w;
        tick();
        host_req = 1'b0;
        chk("R14 write ack", {31'b0, host_ack}, 32'd1);
        tick();
    endtask

    task automatic host_rd(output logic [31:0] d);
        host_req = 1'b1; host_we = 1'b0;
        tick();
        host_req = 1'b0;
        chk("R14 read ack", {31'b0, host_ack}, 32'd1);
        d = host_rdata;
        tick();
        chk("R14 ack single pulse", {31'b0, host_ack}, 32'd0);
    endtask

    task automatic pop_byte(output logic [7:0] b);
        b = tx_byte;
        tx_ready = 1'b1;
        tick();
        tx_ready = 1'b0;
    endtask

    task automatic push_byte(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b;
        tick();
        rx_valid = 1'b0;
    endtask

    function automatic logic [31:0] reqv();
        return {27'b0, data_irq, req_last_burst, req_burst, req_last_single, req_single};
    endfunction

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        logic [7:0]  b;
        logic [31:0] d;
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 tx_valid", {31'b0, tx_valid}, 32'd0);
        chk("R1 rx_ready", {31'b0, rx_ready}, 32'd0);
        chk("R1 host_ack", {31'b0, host_ack}, 32'd0);
        chk("R1 requests", reqv(), 32'd0);
        chk("R1 err_flags", {28'b0, err_flags}, 32'd0);

        // R2 R3 R5 unpacking table
        for (int k = 0; k < 6; k++) begin
            start_pkg(1'b0, VEC[k][71:70], 6'd0, {13'b0, VEC[k][69:67]}, 16'd0);
            host_wr(VEC[k][66:35]);
            for (int j = 0; j < int'(VEC[k][34:32]); j++) begin
                chk("R2 tx_valid", {31'b0, tx_valid}, 32'd1);
                pop_byte(b);
                chk("R2 R3 byte", {24'b0, b}, {24'b0, VEC[k][8*j +: 8]});
            end
            chk("R5 no surplus bytes", {31'b0, tx_valid}, 32'd0);
        end
        chk("R9 no error in table", {28'b0, err_flags}, 32'd0);

        // R6 R7 R8 transmit request sequence: burst 8, package 12, word access
        start_pkg(1'b0, 2'd2, 6'd8, 16'd12, 16'd0);
        chk("R6 burst", reqv(), 32'b10100);
        host_wr(32'h03020100);
        chk("R6 last burst", reqv(), 32'b11000);
        host_wr(32'h07060504);
        chk("R7 last single", reqv(), 32'b10010);
        host_wr(32'h0B0A0908);
        chk("R7 none at end", reqv(), 32'd0);
        host_wr(32'hFFFFFFFF);
        chk("R9 write after package", {28'b0, err_flags}, 32'h1);
        for (int j = 0; j < 12; j++) begin
            pop_byte(b);
            chk("R2 sequence byte", {24'b0, b}, j);
        end
        chk("R9 dropped write", {31'b0, tx_valid}, 32'd0);
        // R13 sticky and per-bit clear
        tick(); tick();
        chk("R13 flag holds", {28'b0, err_flags}, 32'h1);
        err_clr = 4'b1110; tick(); err_clr = 4'h0;
        chk("R13 other bits clear nothing", {28'b0, err_flags}, 32'h1);
        err_clr = 4'b0001; tick(); err_clr = 4'h0;
        chk("R13 w1c", {28'b0, err_flags}, 32'h0);

        // R7 single request
        start_pkg(1'b0, 2'd0, 6'd8, 16'd3, 16'd0);
        chk("R7 single", reqv(), 32'b10001);

        // R9 overflow from full buffer
        start_pkg(1'b0, 2'd2, 6'd0, 16'd40, 16'd0);
        for (int j = 0; j < 8; j++) host_wr({4{8'(j)}});
        chk("R9 no error until full", {28'b0, err_flags}, 32'h0);
        host_wr(32'hEEEEEEEE);
        chk("R9 overflow flag", {28'b0, err_flags}, 32'h1);
        for (int j = 0; j < 32; j++) begin
            pop_byte(b);
            if (j % 4 == 0) chk("R9 kept byte", {24'b0, b}, j / 4);
        end
        chk("R9 only 32 bytes stored", {31'b0, tx_valid}, 32'd0);
        clr_all();

        // R10 transmit underflow
        start_pkg(1'b0, 2'd2, 6'd0, 16'd4, 16'd0);
        tx_ready = 1'b1; tick(); tx_ready = 1'b0;
        chk("R10 underflow", {28'b0, err_flags}, 32'h2);
        clr_all();

        // R4 R6 R7 receive packing: package 6, burst 4
        start_pkg(1'b1, 2'd2, 6'd4, 16'd0, 16'd6);
        for (int j = 1; j <= 3; j++) push_byte(8'(j));
        chk("R6 no request below burst", reqv(), 32'd0);
        push_byte(8'd4);
        chk("R6 rx burst", reqv(), 32'b10100);
        host_rd(d);
        chk("R4 packed word", d, 32'h04030201);
        push_byte(8'd5); push_byte(8'd6);
        chk("R7 rx last single", reqv(), 32'b10010);
        host_rd(d);
        chk("R4 partial zero fill", d, 32'h00000605);
        host_rd(d);
        chk("R12 read after package data", d, 32'h0);
        chk("R12 flag after package", {28'b0, err_flags}, 32'h8);
        clr_all();

        // R12 short read discards nothing
        start_pkg(1'b1, 2'd2, 6'd0, 16'd0, 16'd8);
        push_byte(8'h01); push_byte(8'h02);
        host_rd(d);
        chk("R12 short read data", d, 32'h0);
        chk("R12 short read flag", {28'b0, err_flags}, 32'h8);
        push_byte(8'h03); push_byte(8'h04);
        host_rd(d);
        chk("R12 bytes kept", d, 32'h04030201);
        clr_all();

        // R11 receive overflow
        start_pkg(1'b1, 2'd2, 6'd0, 16'd0, 16'd40);
        for (int j = 0; j < 32; j++) push_byte(8'(j));
        chk("R11 ready low when full", {31'b0, rx_ready}, 32'd0);
        chk("R11 no error yet", {28'b0, err_flags}, 32'h0);
        push_byte(8'hAA);
        chk("R11 overflow flag", {28'b0, err_flags}, 32'h4);
        host_rd(d);
        chk("R11 oldest word intact", d, 32'h03020100);

        finish_run();
    end
endmodule